// File: doc/BRIEF.md
# Flag-Merging Audio Word Receiver

This block receives a two-channel serial audio stream from an optical disc decoder and packs each 16-bit sample together with the decoder's quality flags into one 18-bit word. The bit clock, word clock, serial data and the two flag lines arrive asynchronously. They are resynchronised to the system clock, and every rising bit-clock edge is found by edge detection. Data is taken MSB first and right-justified: the word of a channel is made of the last 16 bits captured before the word clock changes level.

When insertion is enabled, the audio sits in the upper 16 bits of the output word. Bit 1 holds the error indication: it is set if the error line was high when the first bit of the upper byte was captured, when the first bit of the lower byte was captured, or both. Bit 0 holds the correction line as it stood when the LSB was captured. When insertion is disabled, both low bits are zero and the audio bits are unchanged.

The finished word leaves through a valid/ready output. The serial source cannot be stalled, so back-pressure is handled by a one-word holding slot. A word stays presented until it is taken. A word that completes while the slot is still full is discarded. A word that completes in the same cycle the slot is being emptied takes its place.

Top module: `cdflag_rx`

## Requirements
- R1: After reset, `out_valid` is low and stays low until a complete word has been received.
- R2: The 16 data bits captured last before a word-clock level change appear in `out_word[17:2]`, MSB first: the first of those 16 bits lands in bit 17 and the last in bit 2.
- R3: `out_left` is 1 for a word received while the word clock was high, and 0 for a word received while it was low.
- R4: With insertion enabled, `out_word[1]` is the OR of the error line at the captures of data bit 15 and data bit 7. The error line at any other bit capture has no effect.
- R5: With insertion enabled, `out_word[0]` equals the correction line at the capture of data bit 0 (the LSB). The correction line at any other bit capture has no effect.
- R6: With insertion disabled, `out_word[1:0]` is 00 whatever the flag lines do, and `out_word[17:2]` is as in R2. The enable is sampled at the bit-clock edge that reveals the word-clock change.
- R7: A word-clock half that holds fewer than 16 bit clocks produces no output word.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` and `out_left` stay unchanged.
- R9: A word that completes while an unaccepted word is held is dropped and never appears at the output. If the slot is empty, or is being accepted in that same cycle, the new word is loaded.
- R10: In a word-clock half longer than 16 bit clocks, only the last 16 bits and the flags tied to them form the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock; data captured on its rising edge |
| wclk_i | input | 1 | Word clock; high marks the left channel |
| sdata_i | input | 1 | Serial audio data, MSB first |
| err_i | input | 1 | Decoder error flag line |
| corr_i | input | 1 | Decoder correction flag line |
| ins_en | input | 1 | Flag insertion enable |
| out_ready | input | 1 | Consumer ready for the held word |
| out_valid | output | 1 | A word is held and presented |
| out_word | output | 18 | Audio in [17:2], error flag [1], correction flag [0] |
| out_left | output | 1 | Channel of the presented word, 1 = left |

## Verification
The assertions assume that each bit-clock phase lasts at least three system clocks, so that every rising edge is seen as a separate single-cycle event. They also assume that the word clock, data and flag lines are steady across the rising bit-clock edge. The stimulus keeps each phase at four system clocks and changes all serial lines only while the bit clock is low. The insertion enable is changed only after the first bit of a half has been captured, so it never moves at the edge that samples it.

// File: rtl/cdflag_pkg.sv
package cdflag_pkg;
  // One resynchronised view of the serial lines besides the bit clock.
  typedef struct packed {
    logic ws;
    logic sd;
    logic err;
    logic corr;
  } line_t;

  localparam int LINE_W = $bits(line_t);
endpackage

// File: rtl/cdflag_sync.sv
module cdflag_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg[i] <= '0;
      else if (i == 0) stg[i] <= d;
      else             stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cdflag_framer.sv
module cdflag_framer
  import cdflag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_s,
  input  line_t             line_s,
  input  logic              ins_en,
  output logic              word_stb,
  output logic [DATA_W+1:0] word_data,
  output logic              word_left
);
  localparam int HALF  = DATA_W / 2;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic              bclk_q;
  logic              rise;
  logic              ws_prev;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] d_hist;
  logic [DATA_W-1:0] e_hist;
  logic              c_last;
  logic [1:0]        flags;

  assign rise  = bclk_s & ~bclk_q;
  assign flags = ins_en ? {e_hist[DATA_W-1] | e_hist[HALF-1], c_last} : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q    <= 1'b0;
      ws_prev   <= 1'b0;
      cnt       <= '0;
      d_hist    <= '0;
      e_hist    <= '0;
      c_last    <= 1'b0;
      word_stb  <= 1'b0;
      word_data <= '0;
      word_left <= 1'b0;
    end else begin
      bclk_q   <= bclk_s;
      word_stb <= 1'b0;
      if (rise) begin
        if (line_s.ws != ws_prev) begin
          if (cnt >= FULL) begin
            word_stb  <= 1'b1;
            word_data <= {d_hist, flags};
            word_left <= ws_prev;
          end
          cnt <= CNT_W'(1);
        end else if (cnt < FULL) begin
          cnt <= cnt + 1'b1;
        end
        ws_prev <= line_s.ws;
        d_hist  <= {d_hist[DATA_W-2:0], line_s.sd};
        e_hist  <= {e_hist[DATA_W-2:0], line_s.err};
        c_last  <= line_s.corr;
      end
    end
  end

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> !word_stb); // R7

  AST_NO_STB_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rise) |-> !word_stb); // R2
endmodule

// File: rtl/cdflag_slot.sv
module cdflag_slot #(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_stb,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_left,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_left
);
  logic take;
  assign take = in_stb & (~out_valid | out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_left  <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_word  <= in_word;
      out_left  <= in_left;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid); // R8

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_word) && $stable(out_left)); // R8

  AST_LOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb && (!out_valid || out_ready) |=> out_valid && out_word == $past(in_word)); // R9
endmodule

// File: rtl/cdflag_rx.sv
module cdflag_rx
  import cdflag_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W     = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              wclk_i,
  input  logic              sdata_i,
  input  logic              err_i,
  input  logic              corr_i,
  input  logic              ins_en,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_left
);
  localparam int SYNC_W = LINE_W + 1;

  logic [SYNC_W-1:0] raw;
  logic [SYNC_W-1:0] synced;
  logic              bclk_s;
  line_t             line_s;
  logic              word_stb;
  logic [WORD_W-1:0] word_data;
  logic              word_left;

  assign raw    = {bclk_i, wclk_i, sdata_i, err_i, corr_i};
  assign bclk_s = synced[SYNC_W-1];
  assign line_s = line_t'(synced[LINE_W-1:0]);

  cdflag_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (synced)
  );

  cdflag_framer #(.DATA_W(DATA_W)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_s    (bclk_s),
    .line_s    (line_s),
    .ins_en    (ins_en),
    .word_stb  (word_stb),
    .word_data (word_data),
    .word_left (word_left)
  );

  cdflag_slot #(.WORD_W(WORD_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_stb    (word_stb),
    .in_word   (word_data),
    .in_left   (word_left),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_left  (out_left)
  );

  AST_STB_ON_BCLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> $past(bclk_s, 1) && !$past(bclk_s, 2)); // R2

  AST_FLAGS_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb && !$past(ins_en) |-> word_data[1:0] == 2'b00); // R6
endmodule

// File: tb/tb_cdflag_rx.sv
`timescale 1ns/1ps
module tb_cdflag_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, wclk = 1'b0, sdata = 1'b0, err = 1'b0, corr = 1'b0;
  logic        ins_en = 1'b1;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [17:0] out_word;
  logic        out_left;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [17:0] w;
    logic        left;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  cdflag_rx dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .wclk_i(wclk), .sdata_i(sdata),
    .err_i(err), .corr_i(corr), .ins_en(ins_en), .out_ready(out_ready),
    .out_valid(out_valid), .out_word(out_word), .out_left(out_left)
  );

  // Monitor: pops the scoreboard on every accepted word
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R7/R9 unexpected word: actual %h left %0b expected none",
                 out_word, out_left);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (out_word !== e.w || out_left !== e.left) begin
          errors++;
          $display("FAIL %s: actual %h left %0b expected %h left %0b",
                   e.tag, out_word, out_left, e.w, e.left);
        end
      end
    end
  end

  task automatic bit_out(input logic ws, input logic d, input logic e, input logic c);
    @(negedge clk);
    bclk = 1'b0; wclk = ws; sdata = d; err = e; corr = c;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Driver: sends one word-clock half and pushes its expected word
  task automatic send_half(input logic ws, input int nbits, input logic [15:0] d,
                           input logic [15:0] ef, input logic [15:0] cf,
                           input logic en, input bit expect_word, input string tag);
    if (expect_word) begin
      exp_t e;
      e.w    = {d, en ? {ef[15] | ef[7], cf[0]} : 2'b00};
      e.left = ws;
      e.tag  = tag;
      sb.push_back(e);
    end
    for (int i = 0; i < nbits; i++) begin
      int j;
      j = nbits - 1 - i;
      if (j < 16) bit_out(ws, d[j], ef[j], cf[j]);
      else        bit_out(ws, 1'($urandom), 1'b1, 1'b1);
      if (i == 0) ins_en = en;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 reset valid", 32'(out_valid), 32'h0);

    // slot0: first half after reset, counted from zero
    send_half(1'b1, 16, 16'hA5C3, 16'h0000, 16'h0000, 1'b1, 1, "R2 plain data left");
    check(out_valid === 1'b0, "R1 no word before first full half", 32'(out_valid), 32'h0);
    send_half(1'b0, 16, 16'h1234, 16'h8000, 16'h0001, 1'b1, 1, "R3 R4 R5 upper-byte err, corr");
    send_half(1'b1, 16, 16'hFFFF, 16'h0080, 16'h0000, 1'b1, 1, "R4 lower-byte err");
    send_half(1'b0, 16, 16'h6E91, 16'h7F7F, 16'hFFFE, 1'b1, 1, "R4 R5 other-bit flags ignored");
    send_half(1'b1, 16, 16'h8001, 16'hFFFF, 16'hFFFF, 1'b0, 1, "R6 insertion disabled");
    send_half(1'b0, 32, 16'h0F0F, 16'h0080, 16'h0001, 1'b1, 1, "R10 long half last 16 bits");
    send_half(1'b1, 10, 16'h03FF, 16'hFFFF, 16'hFFFF, 1'b1, 0, "R7 short half");
    send_half(1'b0, 16, 16'h5A5A, 16'h0000, 16'h0000, 1'b1, 1, "R9 held word");
    out_ready = 1'b0;
    send_half(1'b1, 16, 16'h3C3C, 16'h8080, 16'h0001, 1'b1, 0, "R9 dropped word");
    send_half(1'b0, 16, 16'hC3C3, 16'h0000, 16'h0001, 1'b1, 1, "R8 R9 after release");
    check(out_valid === 1'b1, "R8 valid held", 32'(out_valid), 32'h1);
    check(out_word === {16'h5A5A, 2'b00} && out_left === 1'b0, "R8 R9 held word kept",
          32'(out_word), 32'({16'h5A5A, 2'b00}));
    out_ready = 1'b1;
    send_half(1'b1, 16, 16'h0000, 16'h0000, 16'h0000, 1'b1, 0, "trailing half");
    repeat (40) @(negedge clk);
    check(sb.size() == 0, "R9 all expected words seen", 32'(sb.size()), 32'h0);
    check(out_valid === 1'b0, "R7 R9 no extra word", 32'(out_valid), 32'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule